// File: doc/BRIEF.md
# Scratchpad Load/Store Sequencer

This block is the memory stage of a pipelined core. It accepts one load or store at a time and carries it out against a 32-bit-wide scratchpad. The scratchpad is synchronous, with one cycle of read latency. The block adds a signed 9-bit immediate to a base register value to form the byte address. It checks that the address suits the access size, and it always presents the memory with a word address whose two low bits are cleared. A store writes only the addressed bytes through a lane-enable mask, and the store data is copied across all lanes. A load reads the whole word and picks out the addressed byte or half-word. The result is then widened with sign or zero fill.

While a request is being served, the block holds the pipeline with a stall output. Every request, misaligned or not, takes the same fixed sequence: capture, address, access and finish. Stall drops in the finish cycle, and a one-cycle completion pulse appears in that same cycle. A misaligned request makes no memory access. It reports an error on the completion pulse and still releases the pipeline.

Top module: `spad_lsu`

## Requirements
- R1: The byte address is `req_base` plus `req_offset` read as a two's-complement 9-bit value (range -256 to +255), modulo 2^32.
- R2: Whenever `sp_we` or `sp_rd` is high, `sp_addr[1:0]` is 00 and `sp_addr[31:2]` equals bits 31:2 of the byte address.
- R3: Size encoding is 00 byte, 01 half-word, 10 or 11 word. A half-word at an odd address or a word at an address that is not a multiple of 4 is misaligned. Such a request makes no memory access and raises `err` together with `done`. A misaligned load leaves `ld_data` at zero.
- R4: Store lane enables: a byte at address offset k (0..3) gives only bit k; a half-word at offset 0 gives 0011 and at offset 2 gives 1100; a word gives 1111.
- R5: `sp_wdata` carries the store data copied across lanes: a byte four times, a half-word twice, a word unchanged.
- R6: A signed byte or half-word load fills bits above the loaded item with the item's top bit.
- R7: An unsigned sub-word load fills the upper bits with zero. A word load returns the full word.
- R8: A request seen while `stall` is low is accepted at that clock edge. `stall` is then high for exactly three cycles. `done` pulses for one cycle in the cycle where `stall` first reads low again, and a new request can be accepted at the next edge.
- R9: `req_valid` asserted while `stall` is high is ignored: it causes no memory access and no extra completion.
- R10: An aligned request asserts exactly one of `sp_we` (store) or `sp_rd` (load) for exactly one cycle, and never both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_store | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 00 byte, 01 half, 1x word |
| req_signed | input | 1 | Sign-extend sub-word loads |
| req_base | input | 32 | Base register value |
| req_offset | input | 9 | Signed immediate offset |
| req_wdata | input | 32 | Store data (low bits for sub-word) |
| sp_we | output | 1 | Scratchpad write strobe |
| sp_rd | output | 1 | Scratchpad read strobe |
| sp_addr | output | 32 | Word-aligned scratchpad address |
| sp_be | output | 4 | Write lane enables |
| sp_wdata | output | 32 | Lane-replicated write data |
| sp_rdata | input | 32 | Read word, valid one cycle after `sp_rd` |
| stall | output | 1 | Pipeline hold |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Misalignment flag, valid with `done` |
| ld_data | output | 32 | Extended load result |

## Verification
The hardest cases to reach are the combinations of a negative offset with a sub-word access that lands in the upper lanes, and a request that arrives while the unit is busy. The bench reaches the first with bases that sit just above a word boundary and offsets near both ends of the 9-bit range. It reaches the second by holding a conflicting store request on the inputs during the stalled cycles of a load, then checking that the memory sees no write and that no second completion appears. A misaligned store is followed by a word load of the same location, which shows at the ports that memory was left untouched.

// File: rtl/spad_lsu_pkg.sv
`timescale 1ns/1ps
package spad_lsu_pkg;
  localparam logic [1:0] SZ_BYTE = 2'b00;
  localparam logic [1:0] SZ_HALF = 2'b01;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CALC  = 2'd1,
    ST_ISSUE = 2'd2,
    ST_FIN   = 2'd3
  } lsu_state_e;
endpackage

// File: rtl/spad_lsu_agu.sv
`timescale 1ns/1ps
// Address generation: effective address, word address, lane, alignment, lane enables.
module spad_lsu_agu
  import spad_lsu_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 9,
  parameter int LANES  = 4
) (
  input  logic [ADDR_W-1:0]        base,
  input  logic [OFF_W-1:0]         offset,
  input  logic [1:0]               size,
  output logic [ADDR_W-1:0]        word_addr,
  output logic [$clog2(LANES)-1:0] lane,
  output logic                     misaligned,
  output logic [LANES-1:0]         be
);
  localparam int LSB_W = $clog2(LANES);

  logic [ADDR_W-1:0] eff;

  assign eff       = base + {{(ADDR_W-OFF_W){offset[OFF_W-1]}}, offset};
  assign word_addr = {eff[ADDR_W-1:LSB_W], {LSB_W{1'b0}}};
  assign lane      = eff[LSB_W-1:0];

  always_comb begin
    if (size == SZ_BYTE)      misaligned = 1'b0;
    else if (size == SZ_HALF) misaligned = eff[0];
    else                      misaligned = |eff[LSB_W-1:0];
  end

  for (genvar i = 0; i < LANES; i++) begin : g_be
    assign be[i] = (size == SZ_BYTE) ? (lane == LSB_W'(i)) :
                   (size == SZ_HALF) ? (lane[LSB_W-1:1] == (LSB_W-1)'(i >> 1)) :
                                       1'b1;
  end
endmodule

// File: rtl/spad_lsu_lanes.sv
`timescale 1ns/1ps
// Byte-lane steering: store replication and load extraction with extension.
module spad_lsu_lanes
  import spad_lsu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [1:0]                      size,
  input  logic                            sgn,
  input  logic [$clog2(DATA_W/8)-1:0]     lane_sel,
  input  logic [DATA_W-1:0]               st_data,
  input  logic [DATA_W-1:0]               rd_word,
  output logic [DATA_W-1:0]               st_rep,
  output logic [DATA_W-1:0]               ld_ext
);
  localparam int LANES = DATA_W / 8;

  logic [DATA_W-1:0] shifted;
  logic [7:0]        b_item;
  logic [15:0]       h_item;

  for (genvar i = 0; i < LANES; i++) begin : g_rep
    assign st_rep[8*i +: 8] = (size == SZ_BYTE) ? st_data[7:0] :
                              (size == SZ_HALF) ? st_data[8*(i%2) +: 8] :
                                                  st_data[8*i +: 8];
  end

  assign shifted = rd_word >> {lane_sel, 3'b000};
  assign b_item  = shifted[7:0];
  assign h_item  = shifted[15:0];

  always_comb begin
    if (size == SZ_BYTE)      ld_ext = {{(DATA_W-8){sgn & b_item[7]}}, b_item};
    else if (size == SZ_HALF) ld_ext = {{(DATA_W-16){sgn & h_item[15]}}, h_item};
    else                      ld_ext = rd_word;
  end
endmodule

// File: rtl/spad_lsu.sv
`timescale 1ns/1ps
// Stall-and-resume scratchpad load/store sequencer.
module spad_lsu
  import spad_lsu_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int OFF_W  = 9
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  req_valid,
  input  logic                  req_store,
  input  logic [1:0]            req_size,
  input  logic                  req_signed,
  input  logic [ADDR_W-1:0]     req_base,
  input  logic [OFF_W-1:0]      req_offset,
  input  logic [DATA_W-1:0]     req_wdata,
  output logic                  sp_we,
  output logic                  sp_rd,
  output logic [ADDR_W-1:0]     sp_addr,
  output logic [DATA_W/8-1:0]   sp_be,
  output logic [DATA_W-1:0]     sp_wdata,
  input  logic [DATA_W-1:0]     sp_rdata,
  output logic                  stall,
  output logic                  done,
  output logic                  err,
  output logic [DATA_W-1:0]     ld_data
);
  localparam int LANES = DATA_W / 8;
  localparam int LSB_W = $clog2(LANES);

  lsu_state_e        state;
  logic              r_store, r_signed, r_mis;
  logic [1:0]        r_size;
  logic [ADDR_W-1:0] r_base;
  logic [OFF_W-1:0]  r_offset;
  logic [DATA_W-1:0] r_wdata;
  logic [LSB_W-1:0]  r_lane;

  logic [ADDR_W-1:0] agu_word;
  logic [LSB_W-1:0]  agu_lane;
  logic              agu_mis;
  logic [LANES-1:0]  agu_be;
  logic [DATA_W-1:0] st_rep, ld_ext;

  spad_lsu_agu #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .LANES(LANES)) u_agu (
    .base       (r_base),
    .offset     (r_offset),
    .size       (r_size),
    .word_addr  (agu_word),
    .lane       (agu_lane),
    .misaligned (agu_mis),
    .be         (agu_be)
  );

  spad_lsu_lanes #(.DATA_W(DATA_W)) u_lanes (
    .size     (r_size),
    .sgn      (r_signed),
    .lane_sel (r_lane),
    .st_data  (r_wdata),
    .rd_word  (sp_rdata),
    .st_rep   (st_rep),
    .ld_ext   (ld_ext)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      r_store  <= 1'b0;
      r_signed <= 1'b0;
      r_mis    <= 1'b0;
      r_size   <= '0;
      r_base   <= '0;
      r_offset <= '0;
      r_wdata  <= '0;
      r_lane   <= '0;
      sp_we    <= 1'b0;
      sp_rd    <= 1'b0;
      sp_addr  <= '0;
      sp_be    <= '0;
      sp_wdata <= '0;
      stall    <= 1'b0;
      done     <= 1'b0;
      err      <= 1'b0;
      ld_data  <= '0;
    end else begin
      sp_we <= 1'b0;
      sp_rd <= 1'b0;
      done  <= 1'b0;
      err   <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            r_store  <= req_store;
            r_signed <= req_signed;
            r_size   <= req_size;
            r_base   <= req_base;
            r_offset <= req_offset;
            r_wdata  <= req_wdata;
            stall    <= 1'b1;
            state    <= ST_CALC;
          end
        end
        ST_CALC: begin
          r_lane   <= agu_lane;
          r_mis    <= agu_mis;
          sp_addr  <= agu_word;
          sp_be    <= agu_be;
          sp_wdata <= st_rep;
          if (!agu_mis) begin
            sp_we <= r_store;
            sp_rd <= !r_store;
          end
          state <= ST_ISSUE;
        end
        ST_ISSUE: begin
          state <= ST_FIN;
        end
        ST_FIN: begin
          stall <= 1'b0;
          done  <= 1'b1;
          err   <= r_mis;
          if (!r_store) ld_data <= r_mis ? '0 : ld_ext;
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spad_lsu_chk.sv
`timescale 1ns/1ps
module spad_lsu_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic                clk,
  input logic                rst,
  input logic                req_valid,
  input logic                sp_we,
  input logic                sp_rd,
  input logic [ADDR_W-1:0]   sp_addr,
  input logic [DATA_W/8-1:0] sp_be,
  input logic                stall,
  input logic                done,
  input logic                err
);
  localparam int LSB_W = $clog2(DATA_W/8);

  assert_word_addr_R2: assert property (@(posedge clk) disable iff (rst)
    (sp_we || sp_rd) |-> (sp_addr[LSB_W-1:0] == '0));

  assert_one_strobe_R10: assert property (@(posedge clk) disable iff (rst)
    $onehot0({sp_we, sp_rd}));

  assert_strobe_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    (sp_we || sp_rd) |=> !(sp_we || sp_rd));

  assert_err_no_access_R3: assert property (@(posedge clk) disable iff (rst)
    (done && err) |-> (!$past(sp_we, 2) && !$past(sp_rd, 2)));

  assert_be_nonzero_R4: assert property (@(posedge clk) disable iff (rst)
    sp_we |-> (sp_be != '0));

  assert_release_done_R8: assert property (@(posedge clk) disable iff (rst)
    done |-> !stall);

  assert_fall_with_done_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(stall) |-> done);

  assert_accept_R8: assert property (@(posedge clk) disable iff (rst)
    (!stall && req_valid) |=> stall);

  assert_err_only_done_R3: assert property (@(posedge clk) disable iff (rst)
    err |-> done);
endmodule

bind spad_lsu spad_lsu_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/sim_spad_lsu.sv
`timescale 1ns/1ps
module sim_spad_lsu;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_store = 1'b0, req_signed = 1'b0;
  logic [1:0]  req_size = 2'b00;
  logic [31:0] req_base = '0, req_wdata = '0;
  logic [8:0]  req_offset = '0;
  logic        sp_we, sp_rd, stall, done, err;
  logic [31:0] sp_addr, sp_wdata, ld_data;
  logic [31:0] sp_rdata = '0;
  logic [3:0]  sp_be;

  int vectors = 0;
  int miscompares = 0;

  logic [31:0] ram    [0:255];
  logic [31:0] shadow [0:255];

  always #2.5 clk = ~clk;

  spad_lsu u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_store(req_store),
    .req_size(req_size), .req_signed(req_signed), .req_base(req_base),
    .req_offset(req_offset), .req_wdata(req_wdata), .sp_we(sp_we), .sp_rd(sp_rd),
    .sp_addr(sp_addr), .sp_be(sp_be), .sp_wdata(sp_wdata), .sp_rdata(sp_rdata),
    .stall(stall), .done(done), .err(err), .ld_data(ld_data)
  );

  // Scratchpad model: synchronous, one-cycle read latency.
  always @(posedge clk) begin
    if (sp_we) begin
      for (int k = 0; k < 4; k++)
        if (sp_be[k]) ram[sp_addr[9:2]][8*k +: 8] <= sp_wdata[8*k +: 8];
    end
    if (sp_rd) sp_rdata <= ram[sp_addr[9:2]];
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    miscompares++;
    $display("FAIL R8 watchdog expired act=%h exp=%h", 32'd1, 32'd0);
    summary();
  end

  // One request through the full sequence, checked on every clock.
  task automatic do_op(input bit st, input logic [1:0] sz, input bit sg,
                       input logic [31:0] base, input logic [8:0] off,
                       input logic [31:0] wd, input bit poke);
    logic [31:0] eff, w, exp_wd, exp_ld, sh;
    logic [1:0]  ln;
    logic [3:0]  exp_be;
    bit          mis;
    eff = base + {{23{off[8]}}, off};
    ln  = eff[1:0];
    mis = (sz == 2'b01 && eff[0]) || (sz[1] && ln != 2'b00);
    if (sz == 2'b00)      begin exp_be = 4'b0001 << ln; exp_wd = {4{wd[7:0]}}; end
    else if (sz == 2'b01) begin exp_be = ln[1] ? 4'b1100 : 4'b0011; exp_wd = {2{wd[15:0]}}; end
    else                  begin exp_be = 4'b1111; exp_wd = wd; end
    w  = shadow[eff[9:2]];
    sh = w >> (8 * ln);
    if (mis)              exp_ld = 32'h0;
    else if (sz == 2'b00) exp_ld = sg ? {{24{sh[7]}}, sh[7:0]}   : {24'h0, sh[7:0]};
    else if (sz == 2'b01) exp_ld = sg ? {{16{sh[15]}}, sh[15:0]} : {16'h0, sh[15:0]};
    else                  exp_ld = w;

    @(negedge clk);
    req_valid = 1'b1; req_store = st; req_size = sz; req_signed = sg;
    req_base = base; req_offset = off; req_wdata = wd;
    @(negedge clk); // after capture edge
    chk(stall == 1'b1, "R8 stall raised", {31'h0, stall}, 32'h1);
    chk(!sp_we && !sp_rd, "R10 no early access", {30'h0, sp_we, sp_rd}, 32'h0);
    if (poke) begin
      req_valid = 1'b1; req_store = 1'b1; req_size = 2'b10;
      req_base = 32'h0000_0040; req_offset = 9'h0; req_wdata = 32'hDEAD_BEEF;
    end else req_valid = 1'b0;
    @(negedge clk); // access cycle
    chk(stall == 1'b1, "R8 stall held", {31'h0, stall}, 32'h1);
    if (mis) begin
      chk(!sp_we && !sp_rd, "R3 misaligned no access", {30'h0, sp_we, sp_rd}, 32'h0);
    end else begin
      chk(sp_we == st && sp_rd == !st, "R10 strobe kind", {30'h0, sp_we, sp_rd}, {30'h0, st, !st});
      chk(sp_addr == {eff[31:2], 2'b00}, "R1 R2 word address", sp_addr, {eff[31:2], 2'b00});
      if (st) begin
        chk(sp_be == exp_be, "R4 lane enables", {28'h0, sp_be}, {28'h0, exp_be});
        chk(sp_wdata == exp_wd, "R5 replicated data", sp_wdata, exp_wd);
        for (int k = 0; k < 4; k++)
          if (exp_be[k]) shadow[eff[9:2]][8*k +: 8] = exp_wd[8*k +: 8];
      end
    end
    req_valid = 1'b0;
    @(negedge clk);
    chk(stall == 1'b1 && !done, "R8 third stall cycle", {30'h0, stall, done}, 32'h2);
    chk(!sp_we && !sp_rd, "R10 single strobe", {30'h0, sp_we, sp_rd}, 32'h0);
    @(negedge clk); // finish
    chk(stall == 1'b0 && done == 1'b1, "R8 release with done", {30'h0, stall, done}, 32'h1);
    chk(err == mis, "R3 error flag", {31'h0, err}, {31'h0, mis});
    if (!st) chk(ld_data == exp_ld, sg ? "R6 R7 load value" : "R7 load value", ld_data, exp_ld);
    @(negedge clk);
    chk(!done && !stall && !sp_we && !sp_rd, "R9 idle after completion",
        {28'h0, done, stall, sp_we, sp_rd}, 32'h0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin
      ram[i]    = 32'hA5C3_0000 ^ (i * 32'h0101_0107);
      shadow[i] = 32'hA5C3_0000 ^ (i * 32'h0101_0107);
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!stall && !done && !err && !sp_we && !sp_rd && ld_data == 32'h0, "R8 reset state",
        {27'h0, stall, done, err, sp_we, sp_rd}, 32'h0);

    // Word store and load back (R5, R7)
    do_op(1'b1, 2'b10, 1'b0, 32'h0000_0100, 9'h000, 32'h1122_3344, 1'b0);
    do_op(1'b0, 2'b10, 1'b1, 32'h0000_0100, 9'h000, 32'h0, 1'b0);
    // Byte stores into each lane, then signed and unsigned byte loads (R4, R6, R7)
    for (int k = 0; k < 4; k++)
      do_op(1'b1, 2'b00, 1'b0, 32'h0000_0200, 9'(k), 32'h0000_0080 + 32'(k * 33), 1'b0);
    for (int k = 0; k < 4; k++) begin
      do_op(1'b0, 2'b00, 1'b1, 32'h0000_0200, 9'(k), 32'h0, 1'b0);
      do_op(1'b0, 2'b00, 1'b0, 32'h0000_0200, 9'(k), 32'h0, 1'b0);
    end
    // Half-word store at lane 2 and lane 0, loads both ways (R4, R5, R6, R7)
    do_op(1'b1, 2'b01, 1'b0, 32'h0000_0300, 9'h002, 32'hFFFF_9ABC, 1'b0);
    do_op(1'b1, 2'b01, 1'b0, 32'h0000_0300, 9'h000, 32'h0000_1234, 1'b0);
    do_op(1'b0, 2'b01, 1'b1, 32'h0000_0300, 9'h002, 32'h0, 1'b0);
    do_op(1'b0, 2'b01, 1'b0, 32'h0000_0300, 9'h002, 32'h0, 1'b0);
    do_op(1'b0, 2'b01, 1'b1, 32'h0000_0300, 9'h000, 32'h0, 1'b0);
    // Negative and extreme offsets (R1)
    do_op(1'b0, 2'b10, 1'b0, 32'h0000_0301, 9'h1FF, 32'h0, 1'b0);
    do_op(1'b0, 2'b00, 1'b1, 32'h0000_0200, 9'h100, 32'h0, 1'b0);
    do_op(1'b1, 2'b00, 1'b0, 32'h0000_0100, 9'h0FF, 32'h0000_00E7, 1'b0);
    do_op(1'b0, 2'b10, 1'b0, 32'h0000_01FC, 9'h000, 32'h0, 1'b0);
    // Misaligned accesses (R3): store must leave memory untouched
    do_op(1'b1, 2'b01, 1'b0, 32'h0000_0300, 9'h001, 32'h0000_FFFF, 1'b0);
    do_op(1'b0, 2'b10, 1'b0, 32'h0000_0300, 9'h000, 32'h0, 1'b0);
    do_op(1'b0, 2'b10, 1'b0, 32'h0000_0300, 9'h002, 32'h0, 1'b0);
    do_op(1'b1, 2'b11, 1'b0, 32'h0000_0100, 9'h003, 32'h5555_5555, 1'b0);
    do_op(1'b0, 2'b01, 1'b1, 32'h0000_0100, 9'h1FF, 32'h0, 1'b0);
    // Size code 11 behaves as a word (R3)
    do_op(1'b1, 2'b11, 1'b0, 32'h0000_0104, 9'h000, 32'hCAFE_F00D, 1'b0);
    do_op(1'b0, 2'b11, 1'b0, 32'h0000_0104, 9'h000, 32'h0, 1'b0);
    // Request held during stall is ignored (R9); location 0x40 must be unchanged
    do_op(1'b0, 2'b00, 1'b1, 32'h0000_0100, 9'h001, 32'h0, 1'b1);
    do_op(1'b0, 2'b10, 1'b0, 32'h0000_0040, 9'h000, 32'h0, 1'b0);

    summary();
  end
endmodule